// File: doc/BRIEF.md
# Piecewise-Linear Gamma Correction Pipeline

This unit takes an unsigned 12-bit pixel intensity and returns an 8-bit value that follows the display transfer curve y = 255 * (x / 4095)^(1/2.2). The curve is not stored point by point. Instead it is cut into segments, and each segment holds a straight-line fit: a slope and an intercept. Segments are narrow near zero, where the curve is steepest, and they double in width with every power of two of the input. Each of these octaves is then divided into four equal sub-segments.

No comparator tree is needed to find a segment. The address comes straight from the input bits. Inputs below 4 each get their own segment, with addresses 0 to 3 taken from the two low bits. For any other input, let p be the position of the leading one (2 to 11) and s be the two bits just below it. The address is then 4*(p-1) + s. The bits below s form the offset that multiplies the slope. After one multiply-add, the result is rounded to nearest and clamped to 255.

Samples enter and leave on valid/ready streams. The three pipeline stages advance together, and only when the output register is empty or being drained. As a result, back-pressure from the consumer passes back to the producer in the same cycle through `in_ready`. The unit never drops a sample and never duplicates one.

Top module: `gamma_pwl_unit`

## Requirements
- R1: An input of 0 produces an output of 0.
- R2: An input of 4095 (all ones) produces exactly 255.
- R3: For every input x, the output differs from 255*(x/4095)^(1/2.2) by at most 1.0.
- R4: If `in_ready` stays high, a sample accepted at a clock edge appears on `out_valid`/`out_data` after the third rising edge, counting the accepting edge as the first.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R6: `in_ready` is high whenever `out_ready` is high or `out_valid` is low, and it is low while `out_valid` is high and `out_ready` is low.
- R7: Over the input range 0 to 4095, the outputs are non-decreasing.
- R8: During reset and right after it, `out_valid` is low and `in_ready` is high.
- R9: Each accepted input produces exactly one output, and outputs leave in the order their inputs were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Unit can take a sample this cycle |
| in_data | input | 12 | Linear pixel intensity |
| out_valid | output | 1 | Corrected sample present |
| out_ready | input | 1 | Consumer takes the sample this cycle |
| out_data | output | 8 | Gamma-corrected intensity |

## Verification
The bench sweeps every input code while the consumer stalls at random. This exposes a wrong slope or intercept, an address that is off by one at an octave edge, or a bad offset mask, because any of these breaks the 1-LSB limit or the monotonic order near powers of two. Code 0 and code 4095 are driven with an idle pipeline to pin the endpoints and the three-cycle latency. A rounding or clamping slip shows up there as 1 or 254 at the ends. A stall held for several cycles checks that the output neither moves nor is lost. A broken ready path would drop a sample or overwrite it. The ordered scoreboard would catch that, and so would the expected-value checks.

// File: rtl/gamma_pkg.sv
package gamma_pkg;

  // Ideal transfer curve used to derive coefficients at elaboration time.
  function automatic real curve_val(real x, int in_w, int out_w, real gamma);
    real in_max;
    real out_max;
    in_max  = real'((1 << in_w) - 1);
    out_max = real'((1 << out_w) - 1);
    if (x <= 0.0) return 0.0;
    return out_max * ((x / in_max) ** (1.0 / gamma));
  endfunction

  // Width of segment 'a': octave 0 and 1 use unit-wide pieces, then doubling.
  function automatic int seg_width(int a, int sub_bits);
    int oct;
    oct = a >> sub_bits;
    if (oct == 0) return 1;
    return 1 << (oct - 1);
  endfunction

  function automatic int seg_start(int a, int sub_bits);
    int oct;
    int sub;
    int p;
    oct = a >> sub_bits;
    sub = a & ((1 << sub_bits) - 1);
    if (oct == 0) return sub;
    p = oct + sub_bits - 1;
    return (1 << p) + sub * seg_width(a, sub_bits);
  endfunction

  function automatic real seg_slope(int a, int in_w, int out_w, int sub_bits, real gamma);
    int  w;
    int  s;
    w = seg_width(a, sub_bits);
    s = seg_start(a, sub_bits);
    if (w < 2) return 0.0;
    return (curve_val(real'(s + w), in_w, out_w, gamma) -
            curve_val(real'(s), in_w, out_w, gamma)) / real'(w);
  endfunction

  // Chord intercept, lifted by half the mid-point sag to centre the error.
  function automatic real seg_icpt(int a, int in_w, int out_w, int sub_bits, real gamma);
    int  w;
    int  s;
    real c0;
    real sl;
    real mid;
    w  = seg_width(a, sub_bits);
    s  = seg_start(a, sub_bits);
    c0 = curve_val(real'(s), in_w, out_w, gamma);
    if (w < 4) return c0;
    sl  = seg_slope(a, in_w, out_w, sub_bits, gamma);
    mid = curve_val(real'(s) + real'(w) / 2.0, in_w, out_w, gamma);
    return c0 + 0.5 * (mid - (c0 + sl * real'(w) / 2.0));
  endfunction

  function automatic longint to_fixed(real r, int frac_w);
    return longint'(r * real'(longint'(1) << frac_w));
  endfunction

endpackage

// File: rtl/gamma_seg_decode.sv
module gamma_seg_decode #(
  parameter int IN_W     = 12,
  parameter int SUB_BITS = 2,
  parameter int ADDR_W   = 6,
  parameter int OFF_W    = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              in_valid,
  input  logic [IN_W-1:0]   in_data,
  output logic              s1_valid,
  output logic [ADDR_W-1:0] s1_addr,
  output logic [OFF_W-1:0]  s1_off
);
  localparam int LEAD_W = $clog2(IN_W);

  logic [LEAD_W-1:0] lead;
  logic              found;
  logic [LEAD_W-1:0] shift_amt;
  logic [LEAD_W-1:0] oct;
  logic [IN_W-1:0]   shifted;
  logic [IN_W-1:0]   off_mask;
  logic [ADDR_W-1:0] addr_c;
  logic [OFF_W-1:0]  off_c;

  // Leading-one search, saturated at the minimum octave boundary.
  always_comb begin
    lead  = '0;
    found = 1'b0;
    for (int i = IN_W - 1; i >= SUB_BITS; i--) begin
      if (!found && in_data[i]) begin
        lead  = LEAD_W'(i);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    shift_amt = lead - LEAD_W'(SUB_BITS);
    oct       = shift_amt + LEAD_W'(1);
    shifted   = in_data >> shift_amt;
    off_mask  = (IN_W'(1) << shift_amt) - IN_W'(1);
    if (!found) begin
      addr_c = ADDR_W'(in_data[SUB_BITS-1:0]);
      off_c  = '0;
    end else begin
      addr_c = (ADDR_W'(oct) << SUB_BITS) | ADDR_W'(shifted[SUB_BITS-1:0]);
      off_c  = OFF_W'(in_data & off_mask);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_addr  <= '0;
      s1_off   <= '0;
    end else if (en) begin
      s1_valid <= in_valid;
      s1_addr  <= addr_c;
      s1_off   <= off_c;
    end
  end
endmodule

// File: rtl/gamma_coef_rom.sv
module gamma_coef_rom #(
  parameter int  IN_W     = 12,
  parameter int  OUT_W    = 8,
  parameter int  SUB_BITS = 2,
  parameter int  NSEG     = 44,
  parameter int  ADDR_W   = 6,
  parameter int  OFF_W    = 9,
  parameter int  FRAC_W   = 16,
  parameter int  SLOPE_W  = 17,
  parameter int  ICPT_W   = 25,
  parameter real GAMMA    = 2.2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               s1_valid,
  input  logic [ADDR_W-1:0]  s1_addr,
  input  logic [OFF_W-1:0]   s1_off,
  output logic               s2_valid,
  output logic [SLOPE_W-1:0] s2_slope,
  output logic [ICPT_W-1:0]  s2_icpt,
  output logic [OFF_W-1:0]   s2_off
);
  logic [SLOPE_W-1:0] slope_tbl [NSEG];
  logic [ICPT_W-1:0]  icpt_tbl  [NSEG];

  for (genvar a = 0; a < NSEG; a++) begin : g_entry
    localparam longint SL_Q =
      gamma_pkg::to_fixed(gamma_pkg::seg_slope(a, IN_W, OUT_W, SUB_BITS, GAMMA), FRAC_W);
    localparam longint IC_Q =
      gamma_pkg::to_fixed(gamma_pkg::seg_icpt(a, IN_W, OUT_W, SUB_BITS, GAMMA), FRAC_W);
    assign slope_tbl[a] = SLOPE_W'(SL_Q);
    assign icpt_tbl[a]  = ICPT_W'(IC_Q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_slope <= '0;
      s2_icpt  <= '0;
      s2_off   <= '0;
    end else if (en) begin
      s2_valid <= s1_valid;
      s2_slope <= slope_tbl[s1_addr];
      s2_icpt  <= icpt_tbl[s1_addr];
      s2_off   <= s1_off;
    end
  end
endmodule

// File: rtl/gamma_mac_round.sv
module gamma_mac_round #(
  parameter int OUT_W   = 8,
  parameter int OFF_W   = 9,
  parameter int FRAC_W  = 16,
  parameter int SLOPE_W = 17,
  parameter int ICPT_W  = 25
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               s2_valid,
  input  logic [SLOPE_W-1:0] s2_slope,
  input  logic [ICPT_W-1:0]  s2_icpt,
  input  logic [OFF_W-1:0]   s2_off,
  output logic               out_valid,
  output logic [OUT_W-1:0]   out_data
);
  localparam int PROD_W  = SLOPE_W + OFF_W;
  localparam int ACC_W   = ((PROD_W > ICPT_W) ? PROD_W : ICPT_W) + 1;
  localparam int WHOLE_W = ACC_W - FRAC_W;
  localparam int OUT_MAX = (1 << OUT_W) - 1;

  logic [ACC_W-1:0]   acc;
  logic [ACC_W-1:0]   rnd;
  logic [WHOLE_W-1:0] whole;
  logic [OUT_W-1:0]   sat;

  always_comb begin
    acc   = ACC_W'(s2_icpt) + ACC_W'(s2_slope) * ACC_W'(s2_off);
    rnd   = acc + (ACC_W'(1) << (FRAC_W - 1));
    whole = rnd[ACC_W-1:FRAC_W];
    if (whole > WHOLE_W'(OUT_MAX)) sat = OUT_W'(OUT_MAX);
    else                           sat = OUT_W'(whole);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (en) begin
      out_valid <= s2_valid;
      out_data  <= sat;
    end
  end
endmodule

// File: rtl/gamma_pwl_unit.sv
module gamma_pwl_unit #(
  parameter int  IN_W     = 12,
  parameter int  OUT_W    = 8,
  parameter int  SUB_BITS = 2,
  parameter int  FRAC_W   = 16,
  parameter real GAMMA    = 2.2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data
);
  localparam int NSEG    = (IN_W - SUB_BITS + 1) << SUB_BITS;
  localparam int ADDR_W  = $clog2(NSEG);
  localparam int OFF_W   = IN_W - 1 - SUB_BITS;
  localparam int SLOPE_W = FRAC_W + 1;
  localparam int ICPT_W  = OUT_W + FRAC_W + 1;

  logic               adv;
  logic               s1_valid;
  logic [ADDR_W-1:0]  s1_addr;
  logic [OFF_W-1:0]   s1_off;
  logic               s2_valid;
  logic [SLOPE_W-1:0] s2_slope;
  logic [ICPT_W-1:0]  s2_icpt;
  logic [OFF_W-1:0]   s2_off;

  // Whole pipeline moves when the output slot is free or being taken.
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  gamma_seg_decode #(
    .IN_W(IN_W), .SUB_BITS(SUB_BITS), .ADDR_W(ADDR_W), .OFF_W(OFF_W)
  ) i_decode (
    .clk(clk), .rst_n(rst_n), .en(adv),
    .in_valid(in_valid), .in_data(in_data),
    .s1_valid(s1_valid), .s1_addr(s1_addr), .s1_off(s1_off)
  );

  gamma_coef_rom #(
    .IN_W(IN_W), .OUT_W(OUT_W), .SUB_BITS(SUB_BITS), .NSEG(NSEG),
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .FRAC_W(FRAC_W),
    .SLOPE_W(SLOPE_W), .ICPT_W(ICPT_W), .GAMMA(GAMMA)
  ) i_rom (
    .clk(clk), .rst_n(rst_n), .en(adv),
    .s1_valid(s1_valid), .s1_addr(s1_addr), .s1_off(s1_off),
    .s2_valid(s2_valid), .s2_slope(s2_slope), .s2_icpt(s2_icpt), .s2_off(s2_off)
  );

  gamma_mac_round #(
    .OUT_W(OUT_W), .OFF_W(OFF_W), .FRAC_W(FRAC_W),
    .SLOPE_W(SLOPE_W), .ICPT_W(ICPT_W)
  ) i_mac (
    .clk(clk), .rst_n(rst_n), .en(adv),
    .s2_valid(s2_valid), .s2_slope(s2_slope), .s2_icpt(s2_icpt), .s2_off(s2_off),
    .out_valid(out_valid), .out_data(out_data)
  );
endmodule

// File: rtl/gamma_pwl_checker.sv
module gamma_pwl_checker #(
  parameter int IN_W  = 12,
  parameter int OUT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [IN_W-1:0]  in_data,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_data
);
  a_r1_zero_maps_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid && in_ready && (in_data == '0), 3) && $past(in_ready, 2) && $past(in_ready, 1))
    |-> (out_valid && out_data == '0));

  a_r2_full_maps_full: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid && in_ready && (in_data == '1), 3) && $past(in_ready, 2) && $past(in_ready, 1))
    |-> (out_valid && out_data == '1));

  a_r4_three_cycle_latency: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid && in_ready, 3) && $past(in_ready, 2) && $past(in_ready, 1))
    |-> out_valid);

  a_r5_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r6_ready_when_drained: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready || !out_valid) |-> in_ready);

  a_r6_blocked_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r8_reset_idle: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

bind gamma_pwl_unit gamma_pwl_checker #(.IN_W(IN_W), .OUT_W(OUT_W)) i_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/test_gamma_pwl_unit.sv
module test_gamma_pwl_unit;
  localparam int CLK_PERIOD = 10;
  localparam int IN_W  = 12;
  localparam int OUT_W = 8;
  localparam int NCODE = 1 << IN_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [IN_W-1:0]  in_data = '0;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic [OUT_W-1:0] out_data;

  int n_chk = 0;
  int n_err = 0;
  int exp_q[$];
  int res [NCODE];
  bit sweep_mode  = 1'b0;
  bit stall_en    = 1'b0;
  bit force_stall = 1'b0;
  bit done        = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  gamma_pwl_unit i_gamma_pwl_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic real ref_val(int x);
    if (x <= 0) return 0.0;
    return 255.0 * ((real'(x) / 4095.0) ** (1.0 / 2.2));
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  // Consumer side: driven just after the rising edge.
  always @(posedge clk) begin
    #1;
    if (force_stall)   out_ready = 1'b0;
    else if (stall_en) out_ready = ($urandom % 4) != 0;
    else               out_ready = 1'b1;
  end

  // Scoreboard: sample at falling edge, handshake happens at the next rise.
  int  mon_x;
  real mon_err;
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected output", int'(out_data), -1);
      end else begin
        mon_x   = exp_q.pop_front();
        mon_err = real'(out_data) - ref_val(mon_x);
        if (mon_err < 0.0) mon_err = -mon_err;
        n_chk++;
        if (mon_err > 1.0) begin
          n_err++;
          $display("FAIL R3 x=%0d actual=%0d expected=%f", mon_x, out_data, ref_val(mon_x));
        end
        if (sweep_mode) res[mon_x] = int'(out_data);
      end
    end
  end

  task automatic send(int x);
    in_valid = 1'b1;
    in_data  = IN_W'(x);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    exp_q.push_back(x);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(posedge clk); #1;
  endtask

  // Single sample into an empty pipe; check latency and value.
  task automatic probe(int x, int expv, string req);
    send(x);
    @(negedge clk);
    @(negedge clk);
    check(!out_valid, "R4 early valid", int'(out_valid), 0);
    @(negedge clk);
    check(out_valid, "R4 valid after three edges", int'(out_valid), 1);
    check(int'(out_data) == expv, req, int'(out_data), expv);
    @(posedge clk); #1;
    drain();
  endtask

  initial begin
    int held;
    bit mono_ok;
    int bad_x;
    void'($urandom(32'd20240611));
    idle(3);
    @(negedge clk);
    check(!out_valid, "R8 out_valid in reset", int'(out_valid), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid, "R8 out_valid after reset", int'(out_valid), 0);
    check(in_ready, "R8 in_ready after reset", int'(in_ready), 1);
    @(posedge clk); #1;

    probe(0, 0, "R1 zero input");
    probe(NCODE - 1, 255, "R2 full-scale input");

    // Back-pressure: hold the consumer off and watch the output sit still.
    force_stall = 1'b1;
    idle(1);
    send(2048);
    idle(3);
    @(negedge clk);
    check(out_valid, "R5 valid held", int'(out_valid), 1);
    check(!in_ready, "R6 in_ready low when full", int'(in_ready), 0);
    held = int'(out_data);
    idle(4);
    @(negedge clk);
    check(out_valid, "R5 valid still held", int'(out_valid), 1);
    check(int'(out_data) == held, "R5 data stable", int'(out_data), held);
    @(posedge clk); #1;
    force_stall = 1'b0;
    drain();
    @(negedge clk);
    check(in_ready, "R6 in_ready when drained", int'(in_ready), 1);
    @(posedge clk); #1;

    // Full sweep under random stalls.
    stall_en   = 1'b1;
    sweep_mode = 1'b1;
    for (int x = 0; x < NCODE; x++) begin
      send(x);
      if (($urandom % 8) == 0) idle(1);
    end
    drain();
    sweep_mode = 1'b0;
    check(res[0] == 0, "R1 sweep zero", res[0], 0);
    check(res[NCODE-1] == 255, "R2 sweep full", res[NCODE-1], 255);
    mono_ok = 1'b1;
    bad_x = 0;
    for (int x = 1; x < NCODE; x++) begin
      if (mono_ok && res[x] < res[x-1]) begin
        mono_ok = 1'b0;
        bad_x = x;
      end
    end
    check(mono_ok, "R7 monotonic", res[bad_x], bad_x > 0 ? res[bad_x-1] : 0);

    // Random inputs, random gaps, random stalls.
    for (int k = 0; k < 2000; k++) begin
      send(int'($urandom % NCODE));
      if (($urandom % 5) == 0) idle(int'($urandom % 3));
    end
    drain();
    check(exp_q.size() == 0, "R9 all outputs delivered", exp_q.size(), 0);

    stall_en = 1'b0;
    idle(2);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule